// File: doc/BRIEF.md
# Cascaded Moving-Average DC Remover

This block strips the zero-frequency component from a stream of signed samples. It is a linear-phase highpass filter that needs no multipliers. Internally it runs a chain of boxcar averagers of length D, where D is a power of two. Each averager is a recursive running sum: a comb that subtracts the sample D positions back, followed by an accumulator. The output is the input, delayed by the cascade's group delay, minus the scaled cascade output. A constant input therefore produces exactly zero once the filter's memory is full.

The parameter `NUM_STAGES` selects two or four averagers. The group delay is D-1 samples with two stages and 2D-2 samples with four. The delay-matched input sample is read from a tap part way along the first averager's comb line, so no separate full-length delay line is built. The scaling by 1/D for every stage is applied once, as a single arithmetic right shift of the final sum.

Samples enter on a valid/ready handshake and leave on another. A sample is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle and is held until the consumer takes it with `out_ready`. While an undelivered result waits, `in_ready` is low, so back-pressure from the output reaches the input with no extra buffering.

Top module: `dcr_cascade_ma`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears every delay line, accumulator and the output register. After that edge `out_valid` is 0 and `in_ready` is 1.
- R2: Each accepted sample raises `out_valid` on the following cycle. `out_valid` stays high until a cycle with `out_ready` high, and every accepted sample yields exactly one output.
- R3: While `out_valid` is high and `out_ready` is low, `out_data` holds its value and `in_ready` is low.
- R4: With two stages, sample n gives `out_data` = x[n-(D-1)] - floor(S2[n] / D^2). Here S2 is the two-fold running sum of D-sample windows and samples before reset count as zero.
- R5: With four stages, sample n gives `out_data` = x[n-(2D-2)] - floor(S4[n] / D^4), with S4 the four-fold running sum.
- R6: After 2D (two stages) or 4D (four stages) consecutive equal accepted samples, the output for that sample is exactly zero.
- R7: Results stay exact for full-scale inputs (+2^(N-1)-1, -2^(N-1), and alternating between them), even though the accumulators wrap around in two's complement.
- R8: A sample presented with `in_valid` low, or with `in_ready` low, has no effect on any later output.
- R9: A reset applied mid-stream discards all history. Outputs after it match a stream that started from all-zero history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_data | output | DATA_W+1 | Signed DC-free output sample |

## Verification
Two instances, one with two stages and one with four, receive the same stream and are compared with a direct-form bench model that sums D-sample windows explicitly. Random full-range samples with random gaps and stalls check the filter equations, and show that refused or invalid samples leave the history untouched. Long constant runs, both moderate and at full scale, separate a true zero response at DC from one that only decays. Full-scale runs also force every accumulator to wrap, which exposes any width that is too narrow. An impulse and a reset in the middle of the stream show the delay alignment and show that no history survives the reset.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  // Width that holds the full unscaled cascade sum of a signed input.
  function automatic int acc_width(input int data_w, input int log2_d, input int stages);
    return data_w + stages * log2_d;
  endfunction

  // Delay from input to the centre of the cascaded boxcar response.
  function automatic int group_delay(input int log2_d, input int stages);
    return ((1 << log2_d) - 1) * stages / 2;
  endfunction

endpackage

// File: rtl/dcr_delay_line.sv
module dcr_delay_line #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (shift_en) begin
      mem_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) mem_q[i] <= mem_q[i-1];
    end
  end

  assign dout = mem_q[DEPTH-1];

endmodule

// File: rtl/dcr_ma_stage.sv
module dcr_ma_stage #(
  parameter int ACC_W = 26
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] din,
  input  logic signed [ACC_W-1:0] din_old,
  output logic signed [ACC_W-1:0] sum_out
);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] comb_v;

  // comb: newest minus sample leaving the window; wraps freely
  assign comb_v  = din - din_old;
  assign sum_out = acc_q + comb_v;

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= sum_out;
  end

endmodule

// File: rtl/dcr_cascade_ma.sv
module dcr_cascade_ma
  import dcr_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int LOG2_D     = 5,
  parameter int NUM_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W:0]   out_data
);

  localparam int D     = 1 << LOG2_D;
  localparam int ACC_W = acc_width(DATA_W, LOG2_D, NUM_STAGES);
  localparam int SH    = NUM_STAGES * LOG2_D;
  localparam int OUT_W = DATA_W + 1;

  logic accept;
  logic signed [DATA_W-1:0] x_dm1;   // x[n-(D-1)], tap inside first comb line
  logic signed [DATA_W-1:0] x_dmd;   // x[n-D], end of first comb line
  logic signed [DATA_W-1:0] x_grp;   // x delayed by the group delay
  logic signed [ACC_W-1:0]  stage_in  [NUM_STAGES];
  logic signed [ACC_W-1:0]  stage_old [NUM_STAGES];
  logic signed [ACC_W-1:0]  stage_sum [NUM_STAGES];
  logic signed [ACC_W-1:0]  avg_full;
  logic signed [ACC_W-1:0]  diff_full;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  // First comb line split at D-1 so its tap doubles as the delay match.
  dcr_delay_line #(.WIDTH(DATA_W), .DEPTH(D-1)) u_line_head (
    .clk(clk), .rst(rst), .shift_en(accept), .din(in_data), .dout(x_dm1));

  dcr_delay_line #(.WIDTH(DATA_W), .DEPTH(1)) u_line_tail (
    .clk(clk), .rst(rst), .shift_en(accept), .din(x_dm1), .dout(x_dmd));

  generate
    if (NUM_STAGES == 4) begin : g_quad_delay
      // a further D-1 after the tap gives 2D-2
      dcr_delay_line #(.WIDTH(DATA_W), .DEPTH(D-1)) u_line_ext (
        .clk(clk), .rst(rst), .shift_en(accept), .din(x_dm1), .dout(x_grp));
    end else begin : g_dual_delay
      assign x_grp = x_dm1;
    end
  endgenerate

  generate
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign stage_in[k]  = ACC_W'(in_data);
        assign stage_old[k] = ACC_W'(x_dmd);
      end else begin : g_next
        assign stage_in[k] = stage_sum[k-1];
        dcr_delay_line #(.WIDTH(ACC_W), .DEPTH(D)) u_line (
          .clk(clk), .rst(rst), .shift_en(accept),
          .din(stage_sum[k-1]), .dout(stage_old[k]));
      end
      dcr_ma_stage #(.ACC_W(ACC_W)) u_stage (
        .clk(clk), .rst(rst), .en(accept),
        .din(stage_in[k]), .din_old(stage_old[k]), .sum_out(stage_sum[k]));
    end
  endgenerate

  // one arithmetic shift stands for every 1/D
  assign avg_full  = stage_sum[NUM_STAGES-1] >>> SH;
  assign diff_full = ACC_W'(x_grp) - avg_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= OUT_W'(diff_full);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/dcr_cascade_ma_chk.sv
module dcr_cascade_ma_chk #(
  parameter int DATA_W     = 16,
  parameter int LOG2_D     = 5,
  parameter int NUM_STAGES = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic signed [DATA_W-1:0] in_data,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [DATA_W:0]   out_data
);

  localparam int RUN_MAX = NUM_STAGES * (1 << LOG2_D);
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic              acc_ev;
  logic [RUN_W-1:0]  run_q;
  logic [DATA_W-1:0] last_q;

  assign acc_ev = in_valid && in_ready;

  // length of the current run of equal accepted samples
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      last_q <= '0;
    end else if (acc_ev) begin
      last_q <= in_data;
      if (in_data == last_q) run_q <= (run_q == RUN_W'(RUN_MAX)) ? run_q : run_q + 1'b1;
      else                   run_q <= RUN_W'(1);
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) rst |=> !out_valid);

  a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    acc_ev |=> out_valid);

  a_r2_no_phantom_output: assert property (@(posedge clk) disable iff (rst)
    (!acc_ev && (!out_valid || out_ready)) |=> !out_valid);

  a_r3_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r6_dc_gives_zero: assert property (@(posedge clk) disable iff (rst)
    (acc_ev && in_data == last_q && run_q >= RUN_W'(RUN_MAX - 1)) |=> (out_data == '0));

endmodule

bind dcr_cascade_ma dcr_cascade_ma_chk #(
  .DATA_W(DATA_W), .LOG2_D(LOG2_D), .NUM_STAGES(NUM_STAGES)
) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_dcr_cascade_ma.sv
module test_dcr_cascade_ma;

  localparam int DATA_W = 16;
  localparam int LOG2_D = 5;
  localparam int D      = 1 << LOG2_D;
  localparam int NMAX   = 8192;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [DATA_W-1:0] in_data = '0;
  logic in_ready2, in_ready4, out_valid2, out_valid4;
  logic signed [DATA_W:0] out2, out4;

  dcr_cascade_ma #(.DATA_W(DATA_W), .LOG2_D(LOG2_D), .NUM_STAGES(2)) i_dcr_cascade_ma (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready2), .in_data(in_data),
    .out_valid(out_valid2), .out_ready(out_ready), .out_data(out2));

  dcr_cascade_ma #(.DATA_W(DATA_W), .LOG2_D(LOG2_D), .NUM_STAGES(4)) i_dcr_cascade_ma_quad (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready4), .in_data(in_data),
    .out_valid(out_valid4), .out_ready(out_ready), .out_data(out4));

  int n_cmp = 0;
  int n_bad = 0;

  // direct-form model state
  longint hx [NMAX];
  longint h1 [NMAX];
  longint h2 [NMAX];
  longint h3 [NMAX];
  longint h4 [NMAX];
  int     n_ref = 0;
  longint q2 [$];
  longint q4 [$];
  int     qrun [$];
  int     run_len = 0;
  longint last_x = 0;
  bit     stall_pend = 0;
  longint held2, held4;
  string  xtag = "";

  function automatic longint hv(input int s, input int i);
    if (i < 0) return 0;
    case (s)
      0: return hx[i];
      1: return h1[i];
      2: return h2[i];
      3: return h3[i];
      default: return h4[i];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ref_push(input longint x, output longint e2, output longint e4);
    longint acc;
    hx[n_ref] = x;
    for (int s = 1; s <= 4; s++) begin
      acc = 0;
      for (int j = 0; j < D; j++) acc += hv(s - 1, n_ref - j);
      case (s)
        1: h1[n_ref] = acc;
        2: h2[n_ref] = acc;
        3: h3[n_ref] = acc;
        default: h4[n_ref] = acc;
      endcase
    end
    e2 = hv(0, n_ref - (D - 1)) - (h2[n_ref] >>> (2 * LOG2_D));
    e4 = hv(0, n_ref - (2 * D - 2)) - (h4[n_ref] >>> (4 * LOG2_D));
    n_ref++;
  endtask

  task automatic step(input bit v, input logic signed [DATA_W-1:0] d, input bit rdy);
    longint e2, e4;
    int r;
    @(negedge clk);
    in_valid  = v;
    in_data   = d;
    out_ready = rdy;
    #1;
    if (stall_pend) begin
      check(out_valid2 && longint'(out2) == held2, "R3 hold 2-stage", longint'(out2), held2);
      check(out_valid4 && longint'(out4) == held4, "R3 hold 4-stage", longint'(out4), held4);
    end
    check(out_valid2 == (q2.size() != 0), "R2 valid 2-stage", longint'(out_valid2), longint'(q2.size() != 0));
    check(out_valid4 == (q4.size() != 0), "R2 valid 4-stage", longint'(out_valid4), longint'(q4.size() != 0));
    if (out_valid2 && !rdy)
      check(!in_ready2 && !in_ready4, "R3 ready low", longint'(in_ready2), 0);
    if (out_valid2 && rdy && q2.size() != 0) begin
      e2 = q2.pop_front();
      e4 = q4.pop_front();
      r  = qrun.pop_front();
      check(longint'(out2) == e2, {"R4,R8", xtag}, longint'(out2), e2);
      check(longint'(out4) == e4, {"R5,R8", xtag}, longint'(out4), e4);
      if (r >= 4 * D)
        check(out2 == '0 && out4 == '0, "R6 dc zero", longint'(out2) + longint'(out4), 0);
    end
    stall_pend = out_valid2 && !rdy;
    held2 = longint'(out2);
    held4 = longint'(out4);
    if (v && in_ready2) begin
      if (longint'(d) == last_x) run_len++;
      else run_len = 1;
      last_x = longint'(d);
      ref_push(longint'(d), e2, e4);
      q2.push_back(e2);
      q4.push_back(e4);
      qrun.push_back(run_len);
    end
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (cycles) @(negedge clk);
    rst = 1'b0;
    n_ref = 0;
    q2.delete();
    q4.delete();
    qrun.delete();
    run_len = 0;
    last_x = 0;
    stall_pend = 0;
    for (int i = 0; i < NMAX; i++) begin
      hx[i] = 0; h1[i] = 0; h2[i] = 0; h3[i] = 0; h4[i] = 0;
    end
    #1;
    check(!out_valid2 && !out_valid4, "R1 valid low", longint'(out_valid2), 0);
    check(in_ready2 && in_ready4, "R1 ready high", longint'(in_ready2), 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0d1c));
    do_reset(3);

    // random samples with gaps and stalls (R4 R5 R8)
    for (int i = 0; i < 1200; i++)
      step(($urandom % 4) != 0, DATA_W'($urandom), ($urandom % 4) != 0);

    // moderate constant, continuous then with stalls (R6)
    for (int i = 0; i < 200; i++) step(1'b1, 16'sd12345, 1'b1);
    for (int i = 0; i < 300; i++) step(($urandom % 3) != 0, -16'sd20000, ($urandom % 3) != 0);

    // full scale, forces accumulator wrap (R7)
    xtag = " R7";
    for (int i = 0; i < 1200; i++) step(1'b1, 16'sh7fff, ($urandom % 8) != 0);
    for (int i = 0; i < 600; i++)  step(1'b1, 16'sh8000, 1'b1);
    for (int i = 0; i < 400; i++)  step(1'b1, (i % 2) ? 16'sh8000 : 16'sh7fff, 1'b1);
    xtag = "";

    // mid-stream reset discards history (R9)
    do_reset(2);
    xtag = " R9";
    step(1'b1, 16'sh7fff, 1'b1);
    for (int i = 0; i < 300; i++) step(1'b1, '0, 1'b1);
    xtag = "";
    for (int i = 0; i < 800; i++)
      step(($urandom % 2) != 0, DATA_W'($urandom), ($urandom % 2) != 0);

    // drain: every accepted sample delivered (R2)
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);
    check(q2.size() == 0 && !out_valid2, "R2 drained", longint'(q2.size()), 0);
    finish_run();
  end

endmodule